// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

A single-port synchronous static memory with a two-stage read pipeline and a deferred ("late") write path. On every rising clock edge the block samples a chip select, a power-down request, a write request, a global write request, one write enable per 9-bit byte lane, and the address. A read returns its word through an output register, so the data appears after the second rising edge, counting the edge that took the command. A write takes only its address and byte enables with the command. Its data is sampled from the data-in bus one edge later and parked in an internal write buffer.

The buffered write is committed to the storage array on the next write command. That command's own data is not yet present, so the array port is free to take the older write. Reads never use the array port in the same cycle as a write, so the array can map onto a single-port block RAM. A read whose address matches the parked write, or a write whose data is arriving on that same edge, receives the newer bytes merged lane by lane over the array word. Reads and writes may therefore follow each other in any order with no idle cycles. An output enable gates the data-out bus without reference to the clock.

Depth and width are parameters: the address width, the byte-lane width and the number of lanes. With the defaults of 4 lanes of 9 bits the word is 36 bits. With 2 lanes it is 18 bits.

Top module: `lw_sram`

## Requirements
- R1: A read command (sel=1, pwr_dn=0, wr=0, gwr=0) sampled at edge N makes rd_valid=1 and puts its word on the output register after edge N+1. Every other command leaves rd_valid=0 after its N+1 edge.
- R2: A write command (sel=1, pwr_dn=0, wr=1 or gwr=1) takes addr and the lane enables at edge N. It takes its data from din at edge N+1, whatever command is sampled at that edge.
- R3: A read returns the newest value of each byte. This includes writes still held in the buffer and a write whose data is sampled on the same edge as the read command.
- R4: With wr=1 and gwr=0, lane i (bits 9i+8 down to 9i) is written only when bwe[i]=1. bwe=0 writes nothing.
- R5: gwr=1 writes every lane, whatever the values of bwe and wr.
- R6: A deselected cycle (sel=0) changes neither the array nor the pending write, and the output register keeps its value. The data of a write issued one cycle earlier is still taken from din during that cycle.
- R7: pwr_dn=1 overrides sel. The cycle behaves as a deselected cycle even when wr or gwr is set.
- R8: With oe=0, dq_out is all zeros. With oe=1, dq_out shows the output register. A change of oe takes effect without a clock edge.
- R9: After synchronous reset, rd_valid=0, the output register holds zero and no write is pending.
- R10: Any sequence of reads, writes and idle cycles runs without dead cycles. Every read returns what a reference array would return if each write were applied at its command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Synchronous chip select |
| pwr_dn | input | 1 | Synchronous power-down; deselects the cycle |
| wr | input | 1 | Write request qualified by bwe |
| gwr | input | 1 | Global write of all lanes |
| bwe | input | LANES | Per-lane write enables |
| addr | input | ADDR_W | Word address |
| din | input | BYTE_W*LANES | Write data, one cycle after its command |
| oe | input | 1 | Asynchronous output enable |
| dq_out | output | BYTE_W*LANES | Read data bus, zero when disabled |
| rd_valid | output | 1 | Output register holds data of a read |

## Verification
The assertions assume three things about the inputs. Every input is stable around the rising edge. din carries the data of a write on the cycle after that write's command. Reset is held long enough that the two-cycle read pipeline starts empty. The bench drives all inputs one time unit after the edge, and always places the previous write's data on din in the following cycle, including when that cycle is deselected or powered down. It also fills the whole array with full-word writes before any read, so no array byte is read before it has been written.

// File: rtl/lw_pkg.sv
package lw_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } lw_cmd_e;

endpackage

// File: rtl/lw_cmd_decode.sv
module lw_cmd_decode
  import lw_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel,
  input  logic             pwr_dn,
  input  logic             wr,
  input  logic             gwr,
  input  logic [LANES-1:0] bwe,
  output lw_cmd_e          cmd,
  output logic [LANES-1:0] mask
);

  // power-down wins over select; any write request makes a write cycle
  always_comb begin
    if (!sel || pwr_dn)  cmd = CMD_IDLE;
    else if (wr || gwr)  cmd = CMD_WRITE;
    else                 cmd = CMD_READ;
  end

  always_comb begin
    if (gwr)      mask = {LANES{1'b1}};
    else if (wr)  mask = bwe;
    else          mask = '0;
  end

endmodule

// File: rtl/lw_write_buf.sv
module lw_write_buf
  import lw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  lw_cmd_e           cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] din,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [LANES-1:0]  commit_mask,
  output logic [DATA_W-1:0] commit_data,
  output logic [LANES-1:0]  fwd_mask,
  output logic [DATA_W-1:0] fwd_data,
  output logic              lag_valid_o,
  output logic              hold_valid_o
);

  // lag stage: write command taken, data not yet sampled
  logic              lag_valid;
  logic [ADDR_W-1:0] lag_addr;
  logic [LANES-1:0]  lag_mask;

  // hold stage: newest complete write
  logic              hold_valid;
  logic              hold_dirty;
  logic [ADDR_W-1:0] hold_addr;
  logic [LANES-1:0]  hold_mask;
  logic [DATA_W-1:0] hold_data;

  logic is_wr;
  assign is_wr = (cmd == CMD_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      lag_valid  <= 1'b0;
      hold_valid <= 1'b0;
      hold_dirty <= 1'b0;
    end else begin
      lag_valid <= is_wr;
      if (lag_valid) begin
        hold_valid <= 1'b1;
        // committed on this same edge when a new write arrives
        hold_dirty <= !is_wr;
      end else if (is_wr) begin
        hold_dirty <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (is_wr) begin
      lag_addr <= addr;
      lag_mask <= mask;
    end
    if (lag_valid) begin
      hold_addr <= lag_addr;
      hold_mask <= lag_mask;
      hold_data <= din;
    end
  end

  // a write command frees the array port for the older write
  assign commit_en   = is_wr && (lag_valid || hold_dirty);
  assign commit_addr = lag_valid ? lag_addr : hold_addr;
  assign commit_mask = lag_valid ? lag_mask : hold_mask;
  assign commit_data = lag_valid ? din      : hold_data;

  logic hit_lag, hit_hold;
  assign hit_lag  = lag_valid  && (lag_addr  == addr);
  assign hit_hold = hold_valid && (hold_addr == addr);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    always_comb begin
      if (hit_lag && lag_mask[l]) begin
        fwd_mask[l]                   = 1'b1;
        fwd_data[l*BYTE_W +: BYTE_W]  = din[l*BYTE_W +: BYTE_W];
      end else if (hit_hold && hold_mask[l]) begin
        fwd_mask[l]                   = 1'b1;
        fwd_data[l*BYTE_W +: BYTE_W]  = hold_data[l*BYTE_W +: BYTE_W];
      end else begin
        fwd_mask[l]                   = 1'b0;
        fwd_data[l*BYTE_W +: BYTE_W]  = '0;
      end
    end
  end

  assign lag_valid_o  = lag_valid;
  assign hold_valid_o = hold_valid;

endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  wmask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  // one single-port memory per lane; read data changes only on reads
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] q_l;

    always_ff @(posedge clk) begin
      if (we && wmask[l])
        mem[addr] <= wdata[l*BYTE_W +: BYTE_W];
      if (re)
        q_l <= mem[addr];
    end

    assign q[l*BYTE_W +: BYTE_W] = q_l;
  end

endmodule

// File: rtl/lw_read_stage.sv
module lw_read_stage #(
  parameter int BYTE_W = 9,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_now,
  input  logic [LANES-1:0]  fwd_mask,
  input  logic [DATA_W-1:0] fwd_data,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] dout_q,
  output logic              rd_valid
);

  logic              rd_p;
  logic [LANES-1:0]  fm_q;
  logic [DATA_W-1:0] fd_q;
  logic [DATA_W-1:0] merged;

  always_ff @(posedge clk) begin
    if (rd_now) begin
      fm_q <= fwd_mask;
      fd_q <= fwd_data;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*BYTE_W +: BYTE_W] =
      fm_q[l] ? fd_q[l*BYTE_W +: BYTE_W] : ram_q[l*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p     <= 1'b0;
      rd_valid <= 1'b0;
      dout_q   <= '0;
    end else begin
      rd_p     <= rd_now;
      rd_valid <= rd_p;
      if (rd_p) dout_q <= merged;
    end
  end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              pwr_dn,
  input  logic              wr,
  input  logic              gwr,
  input  logic [LANES-1:0]  bwe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe,
  output logic [DATA_W-1:0] dq_out,
  output logic              rd_valid
);

  lw_cmd_e           cmd;
  logic [LANES-1:0]  cmd_mask;
  logic              arr_we, arr_re;
  logic [ADDR_W-1:0] commit_addr, arr_addr;
  logic [LANES-1:0]  commit_mask, fwd_mask;
  logic [DATA_W-1:0] commit_data, fwd_data, ram_q, dout_q;
  logic              wa_valid, buf_valid;

  lw_cmd_decode #(.LANES(LANES)) u_dec (
    .sel    (sel),
    .pwr_dn (pwr_dn),
    .wr     (wr),
    .gwr    (gwr),
    .bwe    (bwe),
    .cmd    (cmd),
    .mask   (cmd_mask)
  );

  lw_write_buf #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) u_wbuf (
    .clk          (clk),
    .rst          (rst),
    .cmd          (cmd),
    .addr         (addr),
    .mask         (cmd_mask),
    .din          (din),
    .commit_en    (arr_we),
    .commit_addr  (commit_addr),
    .commit_mask  (commit_mask),
    .commit_data  (commit_data),
    .fwd_mask     (fwd_mask),
    .fwd_data     (fwd_data),
    .lag_valid_o  (wa_valid),
    .hold_valid_o (buf_valid)
  );

  assign arr_re   = (cmd == CMD_READ);
  assign arr_addr = arr_re ? addr : commit_addr;

  lw_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .re    (arr_re),
    .addr  (arr_addr),
    .wmask (commit_mask),
    .wdata (commit_data),
    .q     (ram_q)
  );

  lw_read_stage #(.BYTE_W(BYTE_W), .LANES(LANES)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_now   (arr_re),
    .fwd_mask (fwd_mask),
    .fwd_data (fwd_data),
    .ram_q    (ram_q),
    .dout_q   (dout_q),
    .rd_valid (rd_valid)
  );

  // output drivers follow oe with no clock involved
  assign dq_out = oe ? dout_q : '0;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              pwr_dn,
  input logic              wr,
  input logic              gwr,
  input logic              rd_valid,
  input logic [DATA_W-1:0] dout_q,
  input logic              arr_we,
  input logic              arr_re,
  input logic              wa_valid,
  input logic              buf_valid
);

  logic rd_cmd;
  assign rd_cmd = sel && !pwr_dn && !wr && !gwr;

  p_read_latency_r1: assert property (@(posedge clk) disable iff (rst)
    rd_cmd |=> ##1 rd_valid);

  p_valid_source_r1: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_cmd, 2));

  p_data_lag_r2: assert property (@(posedge clk) disable iff (rst)
    wa_valid |=> buf_valid);

  p_idle_array_r6: assert property (@(posedge clk) disable iff (rst)
    !(sel && !pwr_dn) |-> (!arr_we && !arr_re));

  p_hold_out_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_cmd |=> ##1 $stable(dout_q));

  p_pd_override_r7: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> ##1 !rd_valid);

  p_port_single_r10: assert property (@(posedge clk) disable iff (rst)
    !(arr_we && arr_re));

endmodule

bind lw_sram lw_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel       (sel),
  .pwr_dn    (pwr_dn),
  .wr        (wr),
  .gwr       (gwr),
  .rd_valid  (rd_valid),
  .dout_q    (dout_q),
  .arr_we    (arr_we),
  .arr_re    (arr_re),
  .wa_valid  (wa_valid),
  .buf_valid (buf_valid)
);

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;

  localparam int ADDR_W = 8;
  localparam int BYTE_W = 9;
  localparam int LANES  = 4;
  localparam int DATA_W = BYTE_W * LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sel = 1'b0, pwr_dn = 1'b0, wr = 1'b0, gwr = 1'b0;
  logic [LANES-1:0]  bwe = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic              oe = 1'b1;
  logic [DATA_W-1:0] dq_out;
  logic              rd_valid;

  always #2.5 clk = ~clk;

  lw_sram #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) dut (
    .clk(clk), .rst(rst), .sel(sel), .pwr_dn(pwr_dn), .wr(wr), .gwr(gwr),
    .bwe(bwe), .addr(addr), .din(din), .oe(oe), .dq_out(dq_out),
    .rd_valid(rd_valid)
  );

  int n_chk = 0;
  int n_err = 0;
  string tag = "R9";

  logic [DATA_W-1:0] ref_mem [DEPTH];
  logic              pend_v = 1'b0;
  logic [DATA_W-1:0] pend_d = '0;
  logic              s1_v = 1'b0;
  logic [DATA_W-1:0] s1_d = '0;
  logic [DATA_W-1:0] exp_hold = '0;

  task automatic chk(input string what, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock cycle: drive command, apply it to the reference, check outputs
  task automatic cyc(input logic s, input logic p, input logic w, input logic g,
                     input logic [LANES-1:0] be, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] d);
    logic is_wr, is_rd;
    logic [LANES-1:0] m;
    sel = s; pwr_dn = p; wr = w; gwr = g; bwe = be; addr = a;
    din = pend_v ? pend_d : '0;
    is_wr = s && !p && (w || g);
    is_rd = s && !p && !w && !g;
    m = g ? {LANES{1'b1}} : (w ? be : '0);
    if (is_wr)
      for (int l = 0; l < LANES; l++)
        if (m[l]) ref_mem[a][l*BYTE_W +: BYTE_W] = d[l*BYTE_W +: BYTE_W];
    pend_v = is_wr;
    pend_d = d;
    @(posedge clk);
    #1;
    chk("rd_valid", DATA_W'(rd_valid), DATA_W'(s1_v));
    if (s1_v) exp_hold = s1_d;
    chk("dq_out", dq_out, exp_hold);
    s1_v = is_rd;
    s1_d = ref_mem[a];
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    cyc(1, 0, 0, 0, '0, a, '0);
  endtask

  task automatic wrb(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] be,
                     input logic [DATA_W-1:0] d);
    cyc(1, 0, 1, 0, be, a, d);
  endtask

  task automatic wrg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    cyc(1, 0, 0, 1, '0, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 1, '1, ADDR_W'(i * 7), '1);
  endtask

  function automatic logic [DATA_W-1:0] rnd();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[DATA_W-1:0];
  endfunction

  task automatic t_reset_r9();
    tag = "R9";
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    chk("rd_valid after reset", DATA_W'(rd_valid), '0);
    chk("dq_out after reset", dq_out, '0);
    tag = "R9 idle";
    idle(2);
  endtask

  task automatic t_fill_r2();
    tag = "R2 fill";
    for (int i = 0; i < DEPTH; i++) wrg(ADDR_W'(i), rnd());
    idle(1);
  endtask

  task automatic t_basic_r1();
    tag = "R1";
    rd(3); rd(4); idle(1); rd(200); rd(3); idle(3);
  endtask

  task automatic t_forward_r3();
    tag = "R3";
    wrg(10, rnd()); rd(10);
    wrb(10, 4'b0010, rnd()); wrb(10, 4'b0100, rnd()); rd(10); rd(11);
    wrb(12, 4'b1001, rnd()); idle(1); rd(12);
    wrg(13, rnd()); wrb(13, 4'b1000, rnd()); idle(2); rd(13);
    idle(2);
  endtask

  task automatic t_bytes_r4();
    tag = "R4";
    wrb(20, 4'b0101, rnd()); idle(1); wrb(21, 4'b0000, rnd()); idle(1);
    rd(20); rd(21);
    wrb(22, 4'b1000, rnd()); wrg(23, rnd()); rd(22); idle(2);
  endtask

  task automatic t_global_r5();
    tag = "R5";
    cyc(1, 0, 1, 1, 4'b0001, 30, rnd());
    cyc(1, 0, 0, 1, 4'b0110, 31, rnd());
    rd(30); rd(31); idle(2);
  endtask

  task automatic t_deselect_r6();
    tag = "R6";
    rd(40); idle(3);
    wrb(41, 4'b0011, rnd()); idle(3); rd(41);
    wrg(42, rnd()); idle(2); wrb(43, 4'b1100, rnd()); rd(42); rd(43);
    idle(2);
  endtask

  task automatic t_powerdown_r7();
    tag = "R7";
    wrg(50, rnd());
    cyc(1, 1, 0, 1, '1, 50, rnd());
    cyc(1, 1, 1, 0, '1, 50, rnd());
    cyc(1, 1, 0, 0, '0, 50, '0);
    rd(50); idle(2);
  endtask

  task automatic t_oe_r8();
    tag = "R8";
    rd(60); idle(2);
    #0.5 oe = 1'b0;
    #0.5 chk("dq_out with oe low", dq_out, '0);
    #0.5 oe = 1'b1;
    #0.5 chk("dq_out with oe high", dq_out, exp_hold);
    idle(1);
  endtask

  task automatic t_mix_r10();
    tag = "R10";
    for (int i = 0; i < 800; i++) begin
      int k;
      logic [ADDR_W-1:0] a;
      k = int'($urandom_range(0, 19));
      a = ADDR_W'($urandom_range(0, 5));
      if (k < 7)       rd(a);
      else if (k < 12) wrb(a, LANES'($urandom_range(0, 15)), rnd());
      else if (k < 15) wrg(a, rnd());
      else if (k < 17) cyc(0, 0, k[0], 1, '1, a, rnd());
      else             cyc(1, 1, k[0], k[1], '1, a, rnd());
    end
    idle(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset_r9();
    t_fill_r2();
    t_basic_r1();
    t_forward_r3();
    t_bytes_r4();
    t_global_r5();
    t_deselect_r6();
    t_powerdown_r7();
    t_oe_r8();
    t_mix_r10();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule